// File: doc/BRIEF.md
# PCM Static-Data Auto-Mute Detector

This block watches a multi-channel stream of signed PCM samples and raises a mute flag for any channel that has carried the same static value for a long, unbroken run. Two values count as static: all bits zero (digital silence) and all bits one (the value -1). A run only builds while the value stays the same. Changing from one static value to the other starts a new run. The first non-static sample on a channel drops that channel's mute at once.

All channels share one sample-valid strobe. Each channel keeps its own run counter and flag, so a silent channel can mute while its neighbours keep playing. A combined mute-pin output is high whenever any channel is muted, and an enable input switches the whole function off. The run length, channel count and sample width are parameters. The default run length is 8192 samples.

Top module: `pcm_static_automute`

## Requirements
- R1: After a synchronous reset, every `ch_mute` bit and `mute_pin` are 0.
- R2: A channel's `ch_mute` goes to 1 on the clock edge that accepts its RUN_LEN-th consecutive valid all-zero sample, and stays 0 after only RUN_LEN-1 such samples.
- R3: A run of RUN_LEN consecutive valid samples with every bit set (-1) mutes the channel in the same way as R2.
- R4: A valid static sample whose value differs from the previous static value (zero to all-ones, or the reverse) restarts the run with a count of one. Mute then needs RUN_LEN samples of the new value.
- R5: A valid sample that is neither all-zero nor all-ones clears that channel's `ch_mute` on the edge that accepts it, and resets its run to zero.
- R6: Cycles with `sample_valid` low change no counter and no flag, whatever `sample_data` holds.
- R7: Channels are independent. Channel c occupies bits [c*SW +: SW] of `sample_data`, and data on one channel never changes another channel's flag.
- R8: The run counter saturates at RUN_LEN, so a static run of any length longer than RUN_LEN keeps the channel muted.
- R9: When `enable` is low, the next edge clears all run counters and mute flags. No channel mutes while `enable` stays low, and after `enable` returns high a full new run is needed.
- R10: `mute_pin` is 1 in exactly the cycles where at least one `ch_mute` bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Auto-mute function enable (1 = active) |
| sample_valid | input | 1 | One valid sample per channel is present this cycle |
| sample_data | input | NCH*SW | Packed signed samples, channel c at [c*SW +: SW] |
| ch_mute | output | NCH | Registered per-channel mute flags |
| mute_pin | output | 1 | Registered OR of all channel mute flags |

## Verification
The bench builds the block with NCH=2, SW=8 and RUN_LEN=16. With these values the mute threshold is reached within a few dozen cycles. The counter is 5 bits wide, so a run of 60 samples goes well past the point where a wrapping counter would roll over at 32 and drop the mute. Two channels are enough to show that one channel mutes while the other is still playing.

// File: rtl/pcm_amute_pkg.sv
package pcm_amute_pkg;
  typedef enum logic [1:0] {
    SK_NONE = 2'd0,
    SK_ZERO = 2'd1,
    SK_ONES = 2'd2
  } sil_kind_t;
endpackage

// File: rtl/pcm_sil_classify.sv
module pcm_sil_classify
  import pcm_amute_pkg::*;
#(
  parameter int SW = 24
) (
  input  logic [SW-1:0] sample,
  output sil_kind_t     kind
);
  always_comb begin
    if (sample == '0)      kind = SK_ZERO;
    else if (&sample)      kind = SK_ONES;
    else                   kind = SK_NONE;
  end
endmodule

// File: rtl/pcm_run_track.sv
module pcm_run_track
  import pcm_amute_pkg::*;
#(
  parameter int RUN_LEN = 8192
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      valid,
  input  sil_kind_t kind,
  output logic      mute_q,
  output logic      mute_d
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  sil_kind_t     last_q, last_d;

  always_comb begin
    cnt_d  = cnt_q;
    last_d = last_q;
    mute_d = mute_q;
    if (!en) begin
      cnt_d  = '0;
      last_d = SK_NONE;
      mute_d = 1'b0;
    end else if (valid) begin
      if (kind == SK_NONE) begin
        cnt_d  = '0;
        last_d = SK_NONE;
      end else if (kind != last_q) begin
        cnt_d  = CW'(1);
        last_d = kind;
      end else if (cnt_q != LIMIT) begin
        cnt_d = cnt_q + 1'b1;
      end
      mute_d = (cnt_d == LIMIT);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      last_q <= SK_NONE;
      mute_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
      mute_q <= mute_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT); // R8
  AST_MUTE_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    mute_q |-> (cnt_q == LIMIT)); // R2
  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (en && valid && kind == SK_NONE) |=> !mute_q); // R5
  AST_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!mute_q && cnt_q == '0)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && !valid) |=> ($stable(mute_q) && $stable(cnt_q))); // R6
endmodule

// File: rtl/pcm_static_automute.sv
module pcm_static_automute
  import pcm_amute_pkg::*;
#(
  parameter int NCH     = 2,
  parameter int SW      = 24,
  parameter int RUN_LEN = 8192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              sample_valid,
  input  logic [NCH*SW-1:0] sample_data,
  output logic [NCH-1:0]    ch_mute,
  output logic              mute_pin
);
  logic [NCH-1:0] mute_next;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sil_kind_t kind;

    pcm_sil_classify #(.SW(SW)) u_class (
      .sample (sample_data[c*SW +: SW]),
      .kind   (kind)
    );

    pcm_run_track #(.RUN_LEN(RUN_LEN)) u_track (
      .clk    (clk),
      .rst    (rst),
      .en     (enable),
      .valid  (sample_valid),
      .kind   (kind),
      .mute_q (ch_mute[c]),
      .mute_d (mute_next[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) mute_pin <= 1'b0;
    else     mute_pin <= |mute_next;
  end

  AST_PIN_MATCH: assert property (@(posedge clk) disable iff (rst)
    mute_pin == (|ch_mute)); // R10
endmodule

// File: tb/test_pcm_static_automute.sv
module test_pcm_static_automute;
  localparam int NCH = 2;
  localparam int SW  = 8;
  localparam int RL  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              enable = 1'b1;
  logic              sample_valid = 1'b0;
  logic [NCH*SW-1:0] sample_data = '0;
  logic [NCH-1:0]    ch_mute;
  logic              mute_pin;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pcm_static_automute #(.NCH(NCH), .SW(SW), .RUN_LEN(RL)) i_pcm_static_automute (
    .clk(clk), .rst(rst), .enable(enable), .sample_valid(sample_valid),
    .sample_data(sample_data), .ch_mute(ch_mute), .mute_pin(mute_pin)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic send(input logic [SW-1:0] a, input logic [SW-1:0] b);
    sample_data  = {b, a};
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    sample_data  = {8'h55, 8'h5A};
    sample_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic release_all();
    send(8'h11, 8'h22);
    check("R5 release both", ch_mute[0] | ch_mute[1], 1'b0);
  endtask

  task automatic t_reset();
    check("R1 ch_mute0 after reset", ch_mute[0], 1'b0);
    check("R1 ch_mute1 after reset", ch_mute[1], 1'b0);
    check("R1 mute_pin after reset", mute_pin, 1'b0);
  endtask

  task automatic t_zero_run();
    for (int i = 0; i < RL - 1; i++) send(8'h00, 8'h05);
    check("R2 no mute at RUN_LEN-1", ch_mute[0], 1'b0);
    check("R10 pin low before mute", mute_pin, 1'b0);
    send(8'h00, 8'h05);
    check("R2 mute at RUN_LEN zeros", ch_mute[0], 1'b1);
    check("R7 other channel unmuted", ch_mute[1], 1'b0);
    check("R10 pin follows mute", mute_pin, 1'b1);
    send(8'h03, 8'h05);
    check("R5 immediate release", ch_mute[0], 1'b0);
    check("R10 pin drops", mute_pin, 1'b0);
    for (int i = 0; i < RL - 1; i++) send(8'h00, 8'h05);
    check("R5 run restarted after release", ch_mute[0], 1'b0);
    release_all();
  endtask

  task automatic t_ones_run();
    for (int i = 0; i < RL - 1; i++) send(8'h01, 8'hFF);
    check("R3 no mute at RUN_LEN-1 ones", ch_mute[1], 1'b0);
    send(8'h01, 8'hFF);
    check("R3 mute at RUN_LEN ones", ch_mute[1], 1'b1);
    check("R7 ch0 unaffected", ch_mute[0], 1'b0);
    check("R10 pin from ch1", mute_pin, 1'b1);
    release_all();
  endtask

  task automatic t_alternate();
    for (int i = 0; i < 10; i++) send(8'h00, 8'h07);
    for (int i = 0; i < RL - 1; i++) send(8'hFF, 8'h07);
    check("R4 switch restarts run", ch_mute[0], 1'b0);
    send(8'hFF, 8'h07);
    check("R4 mute after full new run", ch_mute[0], 1'b1);
    release_all();
  endtask

  task automatic t_valid_gap();
    for (int i = 0; i < 8; i++) send(8'h00, 8'h00);
    idle(20);
    check("R6 idle does not mute", ch_mute[0], 1'b0);
    for (int i = 0; i < 8; i++) send(8'h00, 8'h00);
    check("R6 run survives idle gap", ch_mute[0], 1'b1);
    check("R7 both channels muted", ch_mute[1], 1'b1);
    idle(10);
    check("R6 idle non-static data ignored", ch_mute[0], 1'b1);
    send(8'h00, 8'h40);
    check("R7 ch1 released alone", ch_mute[1], 1'b0);
    check("R7 ch0 stays muted", ch_mute[0], 1'b1);
    check("R10 pin with one channel", mute_pin, 1'b1);
    release_all();
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 60; i++) begin
      send(8'h00, 8'h09);
      if (i >= RL - 1) check("R8 stays muted on long run", ch_mute[0], 1'b1);
    end
    send(8'h80, 8'h09);
    check("R5 release after long run", ch_mute[0], 1'b0);
    release_all();
  endtask

  task automatic t_enable();
    for (int i = 0; i < RL; i++) send(8'h00, 8'h02);
    check("R2 muted before disable", ch_mute[0], 1'b1);
    enable = 1'b0;
    @(negedge clk);
    check("R9 disable clears mute", ch_mute[0], 1'b0);
    check("R9 disable clears pin", mute_pin, 1'b0);
    for (int i = 0; i < RL + 4; i++) send(8'h00, 8'hFF);
    check("R9 no mute while disabled ch0", ch_mute[0], 1'b0);
    check("R9 no mute while disabled ch1", ch_mute[1], 1'b0);
    enable = 1'b1;
    for (int i = 0; i < RL - 1; i++) send(8'h00, 8'h02);
    check("R9 counter cleared by disable", ch_mute[0], 1'b0);
    send(8'h00, 8'h02);
    check("R9 mutes again after full run", ch_mute[0], 1'b1);
    release_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero_run();
    t_ones_run();
    t_alternate();
    t_valid_gap();
    t_saturate();
    t_enable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule